// File: doc/BRIEF.md
# SDI Scrambler and NRZI Line Coder

This block turns parallel component-video words into the bit-serial stream that a serial digital video output stage needs. It runs on the bit clock. A single-cycle `pclk_tick` pulse marks each rising edge of the parallel word clock, and `din` is captured on that pulse. Each captured 10-bit word is shifted out least significant bit first. In coded mode every bit passes through a self-synchronizing scrambler with polynomial x^9 + x^4 + 1. An NRZI stage (x + 1) follows, so the line level toggles on every scrambled one. In raw mode the bits leave uncoded.

Two bus formats are accepted. The 20-bit format carries chroma on `din[9:0]` and luma on `din[19:10]`. Both words come with one tick, so the tick arrives every 20 bit clocks. The 10-bit format carries a multiplexed word on `din[19:10]` only, with a tick every 10 bit clocks. At 270 Mb/s these cadences match word clocks of 13.5 MHz and 27 MHz. `bit_stb` is high for each cycle in which `sd_out` carries a valid line bit.

Top module: `sdi_ser_top`

## Requirements
- R1: While reset is held and in the cycle after it is released, `sd_out` and `bit_stb` are 0.
- R2: Coded mode (`code_en`=1, `alt_enc`=0) emits NRZI(scramble(b)). Scrambled bit s(t) = b(t) xor s(t-9) xor s(t-4), and the line level is the previous level xor s(t). All history is zero after reset. For word 0x001 sent first after reset, the first two line bits are 1, 1.
- R3: Raw mode (`code_en`=0, `alt_enc`=0) emits the data bits unchanged.
- R4: With `wide_bus`=1 a tick yields 20 strobed bits: `din[9:0]` first, then `din[19:10]`.
- R5: With `wide_bus`=0 a tick yields 10 strobed bits from `din[19:10]`. `din[9:0]` has no effect.
- R6: Each word is emitted least significant bit first.
- R7: The first bit of a word appears on `sd_out` with `bit_stb` high two clock edges after the edge that samples the tick, and not earlier.
- R8: With `alt_enc`=1, `bit_stb` stays 0 and `sd_out` stays 0 whatever the data.
- R9: In coded mode after reset, all-zero words give a constant 0 line.
- R10: Ticks spaced exactly one word period apart give an unbroken strobe with no missing or extra bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| code_en | input | 1 | Coding select (high: scramble plus NRZI) |
| alt_enc | input | 1 | Alternate-encoding select; high disables this path |
| wide_bus | input | 1 | 1: 20-bit bus, 0: 10-bit bus |
| pclk_tick | input | 1 | One-cycle pulse marking a word-clock rising edge |
| din | input | 20 | Parallel video data |
| sd_out | output | 1 | Serial line bit |
| bit_stb | output | 1 | High when `sd_out` carries a valid bit |

## Verification
The coded path is driven with varied 10-bit words and with 20-bit chroma/luma pairs. A bench model undoes the NRZI and the descrambling, and the result must equal the words in the expected order. This exposes wrong taps, a wrong NRZI sense, a reversed bit order or swapped halves. An isolated single one and an all-zero run check the scrambler history reset directly, without the model. Raw mode with distinct halves and with junk on the unused low half shows that format selection and bit order are correct apart from coding. A timing probe confirms the two-edge latency, and a disabled-mode run confirms that nothing is strobed.

// File: rtl/sdi_ser_pkg.sv
package sdi_ser_pkg;

    localparam int SYM_W   = 10;                 // bits per video word
    localparam int BUS_W   = 2 * SYM_W;          // parallel bus width
    localparam int CNT_W   = $clog2(SYM_W);      // bit index width
    localparam int SCR_LEN = 9;                  // scrambler order
    localparam int SCR_TAP = 4;                  // inner tap

    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_RAW   = 2'd1,
        MODE_CODED = 2'd2
    } line_mode_e;

    typedef struct packed {
        logic [SYM_W-1:0] shreg;   // word being shifted out
        logic [SYM_W-1:0] hold;    // second word of a wide tick
        logic [CNT_W-1:0] idx;     // bit index within current word
        logic             pend;    // second word still to send
        logic             active;  // a bit is being presented
    } word_state_t;

    function automatic line_mode_e decode_mode(logic code_en, logic alt_enc);
        if (alt_enc)      return MODE_OFF;
        else if (code_en) return MODE_CODED;
        else              return MODE_RAW;
    endfunction

    function automatic logic scramble_bit(logic d, logic [SCR_LEN-1:0] hist);
        return d ^ hist[SCR_LEN-1] ^ hist[SCR_TAP-1];
    endfunction

endpackage

// File: rtl/sdi_word_sel.sv
module sdi_word_sel
    import sdi_ser_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wide_bus,
    input  logic             pclk_tick,
    input  logic [BUS_W-1:0] din,
    output logic             bit_out,
    output logic             bit_vld
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(SYM_W - 1);

    word_state_t st, st_nxt;

    always_comb begin
        st_nxt = st;
        if (pclk_tick) begin
            st_nxt.shreg  = wide_bus ? din[SYM_W-1:0] : din[BUS_W-1:SYM_W];
            st_nxt.hold   = din[BUS_W-1:SYM_W];
            st_nxt.pend   = wide_bus;
            st_nxt.idx    = '0;
            st_nxt.active = 1'b1;
        end else if (st.active) begin
            if (st.idx == LAST_IDX) begin
                st_nxt.idx = '0;
                if (st.pend) begin
                    st_nxt.shreg = st.hold;
                    st_nxt.pend  = 1'b0;
                end else begin
                    st_nxt.active = 1'b0;
                end
            end else begin
                st_nxt.shreg = st.shreg >> 1;
                st_nxt.idx   = st.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= st_nxt;
    end

    assign bit_out = st.shreg[0];
    assign bit_vld = st.active;

    // R7
    tick_loads_chk: assert property (@(posedge clk) disable iff (rst)
        pclk_tick |=> bit_vld);

    // R4
    idx_range_chk: assert property (@(posedge clk) disable iff (rst)
        st.idx <= LAST_IDX);

    // R5
    narrow_no_pend_chk: assert property (@(posedge clk) disable iff (rst)
        (pclk_tick && !wide_bus) |=> !st.pend);

endmodule

// File: rtl/sdi_line_coder.sv
module sdi_line_coder
    import sdi_ser_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  line_mode_e mode,
    input  logic       bit_in,
    input  logic       bit_vld,
    output logic       sd_out,
    output logic       bit_stb
);
    logic [SCR_LEN-1:0] hist;
    logic               nrz_lvl;
    logic               scr;

    assign scr = scramble_bit(bit_in, hist);

    always_ff @(posedge clk) begin
        if (rst) begin
            hist    <= '0;
            nrz_lvl <= 1'b0;
            sd_out  <= 1'b0;
            bit_stb <= 1'b0;
        end else if (bit_vld && mode != MODE_OFF) begin
            bit_stb <= 1'b1;
            if (mode == MODE_CODED) begin
                hist    <= {hist[SCR_LEN-2:0], scr};
                nrz_lvl <= nrz_lvl ^ scr;
                sd_out  <= nrz_lvl ^ scr;
            end else begin
                sd_out  <= bit_in;
            end
        end else begin
            bit_stb <= 1'b0;
            sd_out  <= 1'b0;
        end
    end

    // R8
    off_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_OFF) |=> (!bit_stb && !sd_out));

    // R3
    raw_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_RAW && bit_vld) |=> (sd_out == $past(bit_in)));

    // R2
    coded_stb_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_CODED && bit_vld) |=> bit_stb);

    // R9
    zero_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_CODED && bit_vld && !bit_in && hist == '0 && !nrz_lvl)
            |=> !sd_out);

endmodule

// File: rtl/sdi_ser_top.sv
module sdi_ser_top
    import sdi_ser_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             code_en,
    input  logic             alt_enc,
    input  logic             wide_bus,
    input  logic             pclk_tick,
    input  logic [BUS_W-1:0] din,
    output logic             sd_out,
    output logic             bit_stb
);
    line_mode_e mode;
    logic       ser_bit;
    logic       ser_vld;

    assign mode = decode_mode(code_en, alt_enc);

    sdi_word_sel u_word_sel (
        .clk       (clk),
        .rst       (rst),
        .wide_bus  (wide_bus),
        .pclk_tick (pclk_tick),
        .din       (din),
        .bit_out   (ser_bit),
        .bit_vld   (ser_vld)
    );

    sdi_line_coder u_coder (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .bit_in  (ser_bit),
        .bit_vld (ser_vld),
        .sd_out  (sd_out),
        .bit_stb (bit_stb)
    );

    // R1
    post_reset_idle_chk: assert property (@(posedge clk)
        $past(rst) |-> !bit_stb);

endmodule

// File: tb/sdi_ser_top_tb.sv
module sdi_ser_top_tb_top;
    logic        clk = 0;
    logic        rst = 1;
    logic        code_en = 0, alt_enc = 0, wide_bus = 0, pclk_tick = 0;
    logic [19:0] din = '0;
    logic        sd_out, bit_stb;

    int n_chk = 0, n_fail = 0;
    logic cap [0:1023];
    int   ncap = 0;
    logic expb [0:1023];
    int   nexp = 0;

    always #2.5 clk = ~clk;

    sdi_ser_top dut_i (
        .clk(clk), .rst(rst), .code_en(code_en), .alt_enc(alt_enc),
        .wide_bus(wide_bus), .pclk_tick(pclk_tick), .din(din),
        .sd_out(sd_out), .bit_stb(bit_stb)
    );

    always @(negedge clk) begin
        if (bit_stb && ncap < 1024) begin
            cap[ncap] = sd_out;
            ncap++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; pclk_tick = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        ncap = 0; nexp = 0;
    endtask

    task automatic add_word(input logic [9:0] w);
        for (int i = 0; i < 10; i++) begin
            expb[nexp] = w[i];
            nexp++;
        end
    endtask

    task automatic send(input logic [19:0] d);
        @(negedge clk);
        din = d; pclk_tick = 1;
        @(negedge clk);
        pclk_tick = 0;
        repeat (wide_bus ? 18 : 8) @(negedge clk);
    endtask

    task automatic drain();
        repeat (25) @(negedge clk);
    endtask

    // compare captured stream (decoded when coded) to expected bits
    task automatic compare(input bit coded, input string req);
        logic [8:0] h;
        logic prev, s, b;
        int bad;
        h = '0; prev = 0; bad = 0;
        check(ncap == nexp, {req, " bit count"}, ncap, nexp);
        for (int i = 0; i < ncap && i < nexp; i++) begin
            if (coded) begin
                s = cap[i] ^ prev;
                prev = cap[i];
                b = s ^ h[8] ^ h[3];
                h = {h[7:0], s};
            end else begin
                b = cap[i];
            end
            if (b !== expb[i]) bad++;
        end
        check(bad == 0, {req, " bit mismatches"}, bad, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1;
        repeat (2) @(negedge clk);
        check(sd_out == 0 && bit_stb == 0, "R1 in reset", {sd_out, bit_stb}, 0);
        rst = 0;
        @(negedge clk);
        check(sd_out == 0 && bit_stb == 0, "R1 after release", {sd_out, bit_stb}, 0);
    endtask

    task automatic t_coded_narrow();
        logic [19:0] d;
        code_en = 1; alt_enc = 0; wide_bus = 0;
        do_reset();
        for (int i = 0; i < 12; i++) begin
            d = {10'((i * 173 + 41) ^ (i << 6)), 10'(i * 59 + 3)};
            add_word(d[19:10]);
            send(d);
        end
        drain();
        compare(1, "R2 R5 R10 coded narrow");
    endtask

    task automatic t_coded_wide();
        logic [19:0] d;
        code_en = 1; alt_enc = 0; wide_bus = 1;
        do_reset();
        for (int i = 0; i < 8; i++) begin
            d = {10'(i * 97 + 512), 10'(i * 211 + 64)};
            add_word(d[9:0]);
            add_word(d[19:10]);
            send(d);
        end
        drain();
        compare(1, "R2 R4 R10 coded wide");
    endtask

    task automatic t_raw_wide();
        code_en = 0; alt_enc = 0; wide_bus = 1;
        do_reset();
        add_word(10'h200); add_word(10'h3F0);
        send({10'h3F0, 10'h200});
        add_word(10'h155); add_word(10'h0AA);
        send({10'h0AA, 10'h155});
        drain();
        compare(0, "R3 R4 R6 raw wide");
    endtask

    task automatic t_raw_narrow();
        code_en = 0; alt_enc = 0; wide_bus = 0;
        do_reset();
        add_word(10'h0C1); send({10'h0C1, 10'h3FF});
        add_word(10'h302); send({10'h302, 10'h155});
        drain();
        compare(0, "R3 R5 R6 raw narrow ignores low half");
    endtask

    task automatic t_latency();
        code_en = 0; alt_enc = 0; wide_bus = 0;
        do_reset();
        @(negedge clk);
        din = {10'h001, 10'h000}; pclk_tick = 1;
        @(negedge clk);
        pclk_tick = 0;
        check(bit_stb == 0, "R7 no output after one edge", bit_stb, 0);
        @(negedge clk);
        check(bit_stb == 1 && sd_out == 1, "R7 R6 first bit at second edge", {bit_stb, sd_out}, 3);
        @(negedge clk);
        check(sd_out == 0, "R6 second bit", sd_out, 0);
        drain();
    endtask

    task automatic t_single_one();
        code_en = 1; alt_enc = 0; wide_bus = 0;
        do_reset();
        send({10'h001, 10'h000});
        drain();
        check(ncap == 10 && cap[0] == 1 && cap[1] == 1, "R2 single one first bits",
              {cap[0], cap[1]}, 3);
    endtask

    task automatic t_zero();
        int ones;
        code_en = 1; alt_enc = 0; wide_bus = 1;
        do_reset();
        for (int i = 0; i < 4; i++) send(20'h0);
        drain();
        ones = 0;
        for (int i = 0; i < ncap; i++) if (cap[i]) ones++;
        check(ncap == 80 && ones == 0, "R9 zero words give zero line", ones, 0);
    endtask

    task automatic t_off();
        code_en = 1; alt_enc = 1; wide_bus = 0;
        do_reset();
        send({10'h3FF, 10'h3FF});
        send({10'h2A5, 10'h000});
        drain();
        check(ncap == 0 && sd_out == 0, "R8 disabled mode silent", ncap, 0);
        alt_enc = 0;
    endtask

    initial begin
        #(5ns * 100000);
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_latency();
        t_single_one();
        t_zero();
        t_coded_narrow();
        t_coded_wide();
        t_raw_wide();
        t_raw_narrow();
        t_off();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule